// File: doc/BRIEF.md
# Mailbox-Fed Serial Transmitter

This block turns words placed in a single 24-bit host mailbox into asynchronous serial frames. There is no queue. The host writes a word whose top bit is clear, and that clear bit marks the word as ready. While the block has nothing to send, it looks at the mailbox once per bit period. When it finds a ready word, it copies the low bits into a shift register and writes the empty pattern back into the mailbox, so that the host can load the next word while the current frame is still going out.

Each frame is a low start bit, then the configured number of data bits with the least significant bit first, then an optional parity bit, then a high stop bit. A free-running bit timer sets the length of every bit, and its period is programmable in clock cycles. The line changes level only at bit-timer boundaries. Accepting a word raises a one-cycle interrupt request and a one-cycle DMA request.

Top module: `sertx_mailbox_tx`

## Requirements
- R1: During and after reset, before any write, the serial line is high, the mailbox reads 0x800000 and both request outputs are low.
- R2: A host write loads the whole 24-bit mailbox. Bit 23 equal to 0 marks the word as pending. A second write while the word is still pending replaces it, so only the later word is transmitted.
- R3: In the first cycle of the start bit, the mailbox reads 0x800000, meaning bit 23 is set and the mailbox is empty again.
- R4: The mailbox is examined only at bit-timer ticks, and only while no frame is in progress. A tick occurs once every `period_i` clocks (period at least 2). A word written to an idle block therefore starts between 2 and period+1 cycles after the write cycle. A word written during a frame stays pending until that frame ends.
- R5: The line changes only on bit-timer ticks. The start bit, every data bit, the parity bit and the stop bit each last exactly `period_i` cycles.
- R6: The start bit is low. It is followed by `wlen_i` data bits taken from mailbox bits [wlen-1:0], least significant bit first. Mailbox bits at or above `wlen_i` are not sent.
- R7: When `pmode_i[1]` is 0, no parity bit is sent and the stop bit follows the last data bit directly, whatever the value of `pmode_i[0]`.
- R8: `pmode_i` = 2'b10 selects even parity, and the parity bit is the XOR of the data bits sent. `pmode_i` = 2'b11 selects odd parity, and the parity bit is the inverse of that XOR.
- R9: The stop bit is high. After it the block polls again, so a word already pending starts its start bit in the cycle right after the stop bit ends. With no word pending, the line stays high.
- R10: `irq_o` and `dreq_o` are both high for exactly one cycle, the first cycle of the start bit.
- R11: Word lengths from 1 to 23 are supported, including both limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mb_wr_i | input | 1 | Host write strobe for the mailbox |
| mb_wdata_i | input | 24 | Host write data; bit 23 = 0 marks a ready word |
| mb_rdata_o | output | 24 | Current mailbox contents; bit 23 = 1 means empty |
| period_i | input | 16 | Bit period in clock cycles (at least 2) |
| wlen_i | input | 5 | Data bits per frame (1 to 23) |
| pmode_i | input | 2 | Parity mode: 0x none, 10 even, 11 odd |
| txd_o | output | 1 | Serial line, idles high |
| irq_o | output | 1 | One-cycle interrupt request when a word is accepted |
| dreq_o | output | 1 | One-cycle DMA request when a word is accepted |

## Verification
The assertions rely on three things about the inputs. `period_i` is never below 2, so ticks are never adjacent. `wlen_i` lies between 1 and 23 whenever a word is accepted. `period_i`, `wlen_i` and `pmode_i` do not change while a frame is being sent. The bench changes these settings only after a frame's stop bit has been observed and the line has returned to idle. It uses only periods of 2 or more and word lengths inside the legal range. Before each table write it waits until the mailbox reads back empty. The one exception is the overwrite case, which writes into a pending mailbox on purpose.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   typedef enum logic [1:0] {
      TX_IDLE = 2'd0,
      TX_DATA = 2'd1,
      TX_PAR  = 2'd2,
      TX_STOP = 2'd3
   } tx_state_e;

   // initial parity accumulator: one extra count for odd mode
   function automatic logic parity_seed(input logic [1:0] mode);
      return mode[1] & mode[0];
   endfunction

endpackage

// File: rtl/sertx_bit_timer.sv
module sertx_bit_timer #(
   parameter int PERIOD_W = 16
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [PERIOD_W-1:0] period_i,
   output logic                tick_o
);

   logic [PERIOD_W-1:0] cnt_q;

   assign tick_o = (cnt_q >= (period_i - PERIOD_W'(1)));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + PERIOD_W'(1);
   end

   AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni) tick_o |=> !tick_o); // R4

endmodule

// File: rtl/sertx_mailbox.sv
module sertx_mailbox #(
   parameter int MBOX_W = 24
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [MBOX_W-1:0] wdata_i,
   input  logic              take_i,
   output logic [MBOX_W-1:0] q_o,
   output logic              pending_o
);

   localparam logic [MBOX_W-1:0] EMPTY_WORD = {1'b1, {(MBOX_W-1){1'b0}}};

   logic [MBOX_W-1:0] q_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_q <= EMPTY_WORD;
      else if (wr_i)   q_q <= wdata_i;     // a fresh host word wins over re-arming
      else if (take_i) q_q <= EMPTY_WORD;
   end

   assign q_o       = q_q;
   assign pending_o = ~q_q[MBOX_W-1];

   AST_WRITE_LANDS:   assert property (@(posedge clk_i) disable iff (!rst_ni) wr_i |=> (q_o == $past(wdata_i))); // R2
   AST_EMPTY_ON_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni) (take_i && !wr_i) |=> (q_o == EMPTY_WORD)); // R3
   AST_TAKE_PENDING:  assert property (@(posedge clk_i) disable iff (!rst_ni) take_i |-> pending_o); // R4

endmodule

// File: rtl/sertx_frame_engine.sv
module sertx_frame_engine
   import sertx_pkg::*;
#(
   parameter int DATA_W     = 23,
   parameter int LEN_W      = 5,
   parameter bit HAS_PARITY = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              pending_i,
   input  logic [DATA_W-1:0] word_i,
   input  logic [LEN_W-1:0]  wlen_i,
   input  logic [1:0]        pmode_i,
   output logic              take_o,
   output logic              line_o,
   output logic              req_o
);

   tx_state_e         state_q;
   logic [DATA_W-1:0] shreg_q;
   logic [LEN_W-1:0]  cnt_q;
   logic              par_q;
   logic              par_en_q;
   logic              par_req;

   generate
      if (HAS_PARITY) begin : g_parity
         assign par_req = pmode_i[1];
      end else begin : g_no_parity
         assign par_req = 1'b0;
      end
   endgenerate

   assign take_o = tick_i && (state_q == TX_IDLE) && pending_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q  <= TX_IDLE;
         shreg_q  <= '0;
         cnt_q    <= '0;
         par_q    <= 1'b0;
         par_en_q <= 1'b0;
         line_o   <= 1'b1;
         req_o    <= 1'b0;
      end else begin
         req_o <= take_o;
         if (tick_i) begin
            unique case (state_q)
               TX_IDLE: begin
                  if (pending_i) begin
                     shreg_q  <= word_i;
                     cnt_q    <= wlen_i;
                     par_q    <= parity_seed(pmode_i);
                     par_en_q <= par_req;
                     line_o   <= 1'b0;
                     state_q  <= TX_DATA;
                  end
               end
               TX_DATA: begin
                  line_o  <= shreg_q[0];
                  par_q   <= par_q ^ shreg_q[0];
                  shreg_q <= shreg_q >> 1;
                  cnt_q   <= cnt_q - LEN_W'(1);
                  if (cnt_q == LEN_W'(1)) state_q <= par_en_q ? TX_PAR : TX_STOP;
               end
               TX_PAR: begin
                  line_o  <= par_q;
                  state_q <= TX_STOP;
               end
               TX_STOP: begin
                  line_o  <= 1'b1;
                  state_q <= TX_IDLE;
               end
               default: state_q <= TX_IDLE;
            endcase
         end
      end
   end

   AST_LINE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni) !$stable(line_o) |-> $past(tick_i)); // R5
   AST_REQ_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni) req_o |-> !line_o); // R10
   AST_IDLE_HIGH:    assert property (@(posedge clk_i) disable iff (!rst_ni) (state_q == TX_IDLE) |-> line_o); // R9
   AST_LEN_LEGAL:    assert property (@(posedge clk_i) disable iff (!rst_ni) take_o |-> (wlen_i != '0 && wlen_i <= LEN_W'(DATA_W))); // R11
   AST_DATA_COUNT:   assert property (@(posedge clk_i) disable iff (!rst_ni) (state_q == TX_DATA) |-> (cnt_q != '0)); // R6

endmodule

// File: rtl/sertx_mailbox_tx.sv
module sertx_mailbox_tx #(
   parameter int MBOX_W     = 24,
   parameter int PERIOD_W   = 16,
   parameter bit HAS_PARITY = 1'b1,
   localparam int DATA_W    = MBOX_W - 1,
   localparam int LEN_W     = $clog2(MBOX_W)
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                mb_wr_i,
   input  logic [MBOX_W-1:0]   mb_wdata_i,
   output logic [MBOX_W-1:0]   mb_rdata_o,
   input  logic [PERIOD_W-1:0] period_i,
   input  logic [LEN_W-1:0]    wlen_i,
   input  logic [1:0]          pmode_i,
   output logic                txd_o,
   output logic                irq_o,
   output logic                dreq_o
);

   generate
      if (MBOX_W < 3 || MBOX_W > 64) begin : g_bad_mbox
         $error("sertx_mailbox_tx: MBOX_W must lie in 3..64");
      end
      if (PERIOD_W < 2) begin : g_bad_period
         $error("sertx_mailbox_tx: PERIOD_W must be at least 2");
      end
   endgenerate

   logic              tick;
   logic              take;
   logic              pending;
   logic              req;
   logic [MBOX_W-1:0] mbox;

   sertx_bit_timer #(.PERIOD_W(PERIOD_W)) u_timer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .period_i (period_i),
      .tick_o   (tick)
   );

   sertx_mailbox #(.MBOX_W(MBOX_W)) u_mbox (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (mb_wr_i),
      .wdata_i   (mb_wdata_i),
      .take_i    (take),
      .q_o       (mbox),
      .pending_o (pending)
   );

   sertx_frame_engine #(
      .DATA_W     (DATA_W),
      .LEN_W      (LEN_W),
      .HAS_PARITY (HAS_PARITY)
   ) u_engine (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick),
      .pending_i (pending),
      .word_i    (mbox[DATA_W-1:0]),
      .wlen_i    (wlen_i),
      .pmode_i   (pmode_i),
      .take_o    (take),
      .line_o    (txd_o),
      .req_o     (req)
   );

   assign mb_rdata_o = mbox;
   assign irq_o      = req;
   assign dreq_o     = req;

   AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni) irq_o |=> !irq_o); // R10
   AST_EMPTY_AT_REQ:  assert property (@(posedge clk_i) disable iff (!rst_ni) (irq_o && !$past(mb_wr_i)) |-> mb_rdata_o[MBOX_W-1]); // R3

endmodule

// File: tb/test_sertx_mailbox_tx.sv
module test_sertx_mailbox_tx;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 8;

   typedef struct packed {
      logic [22:0] d;
      logic [4:0]  n;
      logic [1:0]  m;
      logic [15:0] p;
      logic        hp;
      logic        pb;
   } vec_t;

   // data, length, mode, period, parity present, expected parity bit
   localparam vec_t VECS [NVEC] = '{
      '{23'h000055,  5'd8,  2'b00, 16'd4, 1'b0, 1'b0},
      '{23'h0000F3,  5'd8,  2'b10, 16'd3, 1'b1, 1'b0},
      '{23'h000006,  5'd8,  2'b11, 16'd4, 1'b1, 1'b1},
      '{23'h000001,  5'd1,  2'b10, 16'd2, 1'b1, 1'b1},
      '{23'h7FFFFF,  5'd23, 2'b11, 16'd2, 1'b1, 1'b0},
      '{23'h0003A5,  5'd5,  2'b10, 16'd3, 1'b1, 1'b0},
      '{23'h0000AB,  5'd8,  2'b01, 16'd5, 1'b0, 1'b0},
      '{23'h000000,  5'd8,  2'b11, 16'd2, 1'b1, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr = 1'b0;
   logic [23:0] wdata = '0;
   logic [23:0] rdata;
   logic [15:0] period = 16'd4;
   logic [4:0]  wlen = 5'd8;
   logic [1:0]  pmode = 2'b00;
   logic        txd, irq, dreq;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sertx_mailbox_tx i_sertx_mailbox_tx (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .mb_wr_i    (wr),
      .mb_wdata_i (wdata),
      .mb_rdata_o (rdata),
      .period_i   (period),
      .wlen_i     (wlen),
      .pmode_i    (pmode),
      .txd_o      (txd),
      .irq_o      (irq),
      .dreq_o     (dreq)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // one bit slot: sample at its first cycle, then confirm it held to its last
   task automatic slot(input int p, output logic v);
      @(negedge clk);
      v = txd;
      repeat (p - 1) @(negedge clk);
      chk(txd === v, "R5", "bit held for one period", txd, v);
   endtask

   // called at the first cycle of a start bit; returns at the last stop cycle
   task automatic rx_frame(input logic [22:0] d, input int n, input bit hp,
                           input bit pb, input int p, input string tag);
      logic [22:0] got;
      logic        v;
      logic [22:0] mask;
      chk(irq === 1'b1 && dreq === 1'b1, "R10", {tag, " requests at start"}, {irq, dreq}, 2'b11);
      chk(rdata === 24'h800000, "R3", {tag, " mailbox re-armed"}, rdata, 24'h800000);
      @(negedge clk);
      chk(irq === 1'b0 && dreq === 1'b0, "R10", {tag, " requests one cycle"}, {irq, dreq}, 2'b00);
      repeat (p - 2) @(negedge clk);
      chk(txd === 1'b0, "R5", {tag, " start bit length"}, txd, 0);
      got = '0;
      for (int i = 0; i < n; i++) begin
         slot(p, v);
         got[i] = v;
      end
      mask = (23'h1 << n) - 23'h1;
      chk(got === (d & mask), "R6", {tag, " data LSB first"}, got, d & mask);
      if (hp) begin
         slot(p, v);
         chk(v === pb, "R8", {tag, " parity bit"}, v, pb);
      end
      slot(p, v);
      chk(v === 1'b1, "R9", {tag, " stop bit"}, v, 1);
   endtask

   task automatic host_write(input logic [23:0] w);
      @(negedge clk);
      wr = 1'b1;
      wdata = w;
      @(negedge clk);
      wr = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired (R1..R11 incomplete)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      int lat;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(txd === 1'b1, "R1", "line in reset", txd, 1);
      chk(rdata === 24'h800000, "R1", "mailbox in reset", rdata, 24'h800000);
      chk(irq === 1'b0 && dreq === 1'b0, "R1", "requests in reset", {irq, dreq}, 0);
      rst_n = 1'b1;
      repeat (12) @(negedge clk);
      chk(txd === 1'b1 && rdata === 24'h800000, "R1", "idle after reset", {txd, rdata}, {1'b1, 24'h800000});

      // table-driven frames (R6, R7, R8, R11)
      for (int k = 0; k < NVEC; k++) begin
         period = VECS[k].p;
         wlen   = VECS[k].n;
         pmode  = VECS[k].m;
         lat = 0;
         while (rdata[23] !== 1'b1 && lat < 1000) begin
            @(negedge clk);
            lat++;
         end
         @(negedge clk);
         wr = 1'b1;
         wdata = {1'b0, VECS[k].d};
         lat = 0;
         do begin
            @(negedge clk);
            wr = 1'b0;
            lat++;
         end while (txd === 1'b1 && lat < 2000);
         chk(lat >= 2 && lat <= int'(VECS[k].p) + 1, "R4", "start latency from write", lat, VECS[k].p);
         rx_frame(VECS[k].d, int'(VECS[k].n), VECS[k].hp, VECS[k].pb, int'(VECS[k].p), "vector");
         @(negedge clk);
         chk(txd === 1'b1, "R9", "idle after stop", txd, 1);
      end

      // R2/R4/R9: overwrite while busy, back-to-back frame after the stop bit
      period = 16'd3;
      wlen   = 5'd8;
      pmode  = 2'b00;
      repeat (4) @(negedge clk);
      host_write(24'h000011);
      lat = 0;
      while (txd === 1'b1 && lat < 2000) begin
         @(negedge clk);
         lat++;
      end
      fork
         rx_frame(23'h11, 8, 1'b0, 1'b0, 3, "first");
         begin
            @(negedge clk);
            wr = 1'b1;
            wdata = 24'h000022;
            @(negedge clk);
            wdata = 24'h000033;
            @(negedge clk);
            wr = 1'b0;
         end
      join
      chk(rdata === 24'h000033, "R4", "word held pending during frame", rdata, 24'h000033);
      @(negedge clk);
      chk(txd === 1'b0, "R9", "next start right after stop", txd, 0);
      rx_frame(23'h33, 8, 1'b0, 1'b0, 3, "R2 overwrite");
      @(negedge clk);
      chk(txd === 1'b1 && rdata === 24'h800000, "R9", "idle after last frame", {txd, rdata}, {1'b1, 24'h800000});

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule